// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block sits in the decode stage of an in-order pipeline that feeds four execution units of unequal depth. The units are a single-cycle integer path, a four-stage pipelined floating-point adder, a seven-stage pipelined multiplier and a divider that is not pipelined. Each cycle it looks at the decoded instruction waiting in decode and either lets it go or holds it. It holds on a read of a register that still has a result in flight, on a write to a register that an older instruction has not yet written, on a divide while the divider is occupied, and on a write-back cycle that another instruction has already claimed.

Because the units finish after different delays, instructions can complete in a different order from the one they issued in. The block keeps a pending-write flag per register and a map of future write-back cycles, so that every such hazard is resolved before issue. It also drives the write-back strobe and register number for each cycle, and the register-file side can use these directly.

Top module: `fp_issue_interlock`

## Requirements
- R1: While reset is held and on the first cycle after it, every pending-write flag is clear, no write-back is signalled and the divider reads idle, so an instruction with no operands in flight issues at once.
- R2: `issue` is high only when `idValid` is high and no hazard exists, `stall` is high only when `idValid` is high and a hazard exists, and both are low when `idValid` is low.
- R3: An instruction stalls when an enabled source operand names a register whose pending-write flag is set. A register that is being written back in the same cycle counts as free, and a disabled source is not examined.
- R4: An instruction with an enabled destination stalls when that register's pending-write flag is set. The same-cycle write-back exception applies, and an instruction whose destination is disabled makes no such check.
- R5: Unit codes on `idUnit` are 0 integer, 1 add, 2 multiply and 3 divide. An instruction issued in cycle t with an enabled destination has `wbValid` high with `wbReg` equal to its destination in cycle t+L, where L is 1, 4, 7 or DIV_LAT (default 24) for those codes.
- R6: A destination's pending-write flag reads set from the cycle after issue through its write-back cycle and clear in the cycle after that, unless a new writer claimed it in the write-back cycle.
- R7: `divBusy` is high from the cycle after a divide issues through that divide's write-back cycle. A divide presented while it is high stalls even when it has no operand conflict, and non-divide instructions are unaffected by it.
- R8: An instruction with an enabled destination stalls when its write-back cycle t+L has already been claimed by an issued instruction, so at most one write-back occurs per cycle.
- R9: Completion may be out of order: a shorter-latency instruction issued after a longer one writes back first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idValid | input | 1 | An instruction is present in decode |
| idUnit | input | 2 | Target unit: 0 integer, 1 add, 2 multiply, 3 divide |
| idSrcAEn | input | 1 | First source operand is used |
| idSrcA | input | REG_W | First source register |
| idSrcBEn | input | 1 | Second source operand is used |
| idSrcB | input | REG_W | Second source register |
| idDstEn | input | 1 | Instruction writes a destination register |
| idDst | input | REG_W | Destination register |
| issue | output | 1 | Instruction leaves decode this cycle |
| stall | output | 1 | Instruction is held in decode this cycle |
| busyVec | output | NUM_REGS | Pending-write flag per register |
| wbValid | output | 1 | A result is written back this cycle |
| wbReg | output | REG_W | Register written back this cycle |
| divBusy | output | 1 | Divider occupied |

## Verification
The checker watches, on every cycle, that issue and stall are never asserted together and never without a valid instruction. It also watches that nothing issues over a pending source operand or into an occupied divider, that a claimed destination is flagged on the next cycle, and that every write-back names a flagged register. The exact write-back latency of each unit, the end of the pending-write window, out-of-order completion, and the write-port and same-cycle write-back exceptions depend on sequences of many cycles. Only the bench's scripted instruction streams can show these, by comparing issue decisions and write-back timing against hand-derived values.

// File: rtl/iilk_pkg.sv
package iilk_pkg;

  typedef enum logic [1:0] {
    UNIT_INT = 2'd0,
    UNIT_ADD = 2'd1,
    UNIT_MUL = 2'd2,
    UNIT_DIV = 2'd3
  } unit_e;

  // Strobes from the decision logic to the state-holding datapath
  typedef struct packed {
    logic issue;     // instruction leaves decode at this edge
    logic claimDst;  // reserve destination flag and write-back slot
    logic startDiv;  // divider becomes occupied
  } strobe_t;

endpackage

// File: rtl/iilk_ctrl.sv
module iilk_ctrl
  import iilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int INT_LAT  = 1,
  parameter int ADD_LAT  = 4,
  parameter int MUL_LAT  = 7,
  parameter int DIV_LAT  = 24,
  parameter int SLOT_N   = DIV_LAT + 1,
  parameter int LAT_W    = $clog2(SLOT_N)
) (
  input  logic                idValid,
  input  unit_e               idUnit,
  input  logic                idSrcAEn,
  input  logic [REG_W-1:0]    idSrcA,
  input  logic                idSrcBEn,
  input  logic [REG_W-1:0]    idSrcB,
  input  logic                idDstEn,
  input  logic [REG_W-1:0]    idDst,
  input  logic [NUM_REGS-1:0] busyVec,
  input  logic                wbValid,
  input  logic [REG_W-1:0]    wbReg,
  input  logic [SLOT_N-1:0]   slotTaken,
  input  logic                divBusy,
  output strobe_t             stb,
  output logic [LAT_W-1:0]    latSel,
  output logic                stall
);

  logic [NUM_REGS-1:0] effBusy;
  logic rawA, rawB, wawHit, divHold, portClash, hazard;

  // A register written back this cycle no longer blocks anyone
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_eff
    assign effBusy[i] = busyVec[i] & ~(wbValid && (wbReg == REG_W'(i)));
  end

  always_comb begin
    case (idUnit)
      UNIT_INT: latSel = LAT_W'(INT_LAT);
      UNIT_ADD: latSel = LAT_W'(ADD_LAT);
      UNIT_MUL: latSel = LAT_W'(MUL_LAT);
      UNIT_DIV: latSel = LAT_W'(DIV_LAT);
      default:  latSel = LAT_W'(INT_LAT);
    endcase
  end

  always_comb begin
    rawA      = idSrcAEn & effBusy[idSrcA];
    rawB      = idSrcBEn & effBusy[idSrcB];
    wawHit    = idDstEn  & effBusy[idDst];
    divHold   = (idUnit == UNIT_DIV) & divBusy;
    portClash = idDstEn  & slotTaken[latSel];
    hazard    = rawA | rawB | wawHit | divHold | portClash;

    stb.issue    = idValid & ~hazard;
    stb.claimDst = stb.issue & idDstEn;
    stb.startDiv = stb.issue & (idUnit == UNIT_DIV);
    stall        = idValid & hazard;
  end

endmodule

// File: rtl/iilk_dpath.sv
module iilk_dpath
  import iilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int DIV_LAT  = 24,
  parameter int SLOT_N   = DIV_LAT + 1,
  parameter int LAT_W    = $clog2(SLOT_N),
  parameter int CNT_W    = $clog2(DIV_LAT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [LAT_W-1:0]    latSel,
  input  logic [REG_W-1:0]    idDst,
  output logic [NUM_REGS-1:0] busyVec,
  output logic [SLOT_N-1:0]   slotTaken,
  output logic                wbValid,
  output logic [REG_W-1:0]    wbReg,
  output logic                divBusy
);

  // slotTaken[k] / slotTag[k]: write-back due k cycles from now
  logic [REG_W-1:0] slotTag [SLOT_N];
  logic [CNT_W-1:0] divCnt;
  logic [LAT_W-1:0] landIdx;

  assign landIdx = latSel - LAT_W'(1);

  for (genvar k = 0; k < SLOT_N; k++) begin : g_slot
    logic             upV;
    logic [REG_W-1:0] upTag;
    if (k == SLOT_N - 1) begin : g_top
      assign upV   = 1'b0;
      assign upTag = '0;
    end else begin : g_mid
      assign upV   = slotTaken[k+1];
      assign upTag = slotTag[k+1];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slotTaken[k] <= 1'b0;
        slotTag[k]   <= '0;
      end else if (stb.claimDst && (landIdx == LAT_W'(k))) begin
        slotTaken[k] <= 1'b1;
        slotTag[k]   <= idDst;
      end else begin
        slotTaken[k] <= upV;
        slotTag[k]   <= upTag;
      end
    end
  end

  assign wbValid = slotTaken[0];
  assign wbReg   = slotTag[0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_busy
    always_ff @(posedge clk) begin
      if (!rst_n)
        busyVec[i] <= 1'b0;
      else if (stb.claimDst && (idDst == REG_W'(i)))
        busyVec[i] <= 1'b1;
      else if (wbValid && (wbReg == REG_W'(i)))
        busyVec[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      divCnt <= '0;
    else if (stb.startDiv)
      divCnt <= CNT_W'(DIV_LAT);
    else if (divCnt != '0)
      divCnt <= divCnt - CNT_W'(1);
  end

  assign divBusy = (divCnt != '0);

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import iilk_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS),
  parameter int INT_LAT  = 1,
  parameter int ADD_LAT  = 4,
  parameter int MUL_LAT  = 7,
  parameter int DIV_LAT  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idValid,
  input  logic [1:0]          idUnit,
  input  logic                idSrcAEn,
  input  logic [REG_W-1:0]    idSrcA,
  input  logic                idSrcBEn,
  input  logic [REG_W-1:0]    idSrcB,
  input  logic                idDstEn,
  input  logic [REG_W-1:0]    idDst,
  output logic                issue,
  output logic                stall,
  output logic [NUM_REGS-1:0] busyVec,
  output logic                wbValid,
  output logic [REG_W-1:0]    wbReg,
  output logic                divBusy
);

  localparam int MAX_LAT = (DIV_LAT > MUL_LAT) ?
                           ((DIV_LAT > ADD_LAT) ? DIV_LAT : ADD_LAT) :
                           ((MUL_LAT > ADD_LAT) ? MUL_LAT : ADD_LAT);
  localparam int SLOT_N  = ((MAX_LAT > INT_LAT) ? MAX_LAT : INT_LAT) + 1;
  localparam int LAT_W   = $clog2(SLOT_N);

  strobe_t           stb;
  logic [LAT_W-1:0]  latSel;
  logic [SLOT_N-1:0] slotTaken;

  iilk_ctrl #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W),
    .INT_LAT(INT_LAT), .ADD_LAT(ADD_LAT), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT),
    .SLOT_N(SLOT_N), .LAT_W(LAT_W)
  ) u_ctrl (
    .idValid  (idValid),
    .idUnit   (unit_e'(idUnit)),
    .idSrcAEn (idSrcAEn),
    .idSrcA   (idSrcA),
    .idSrcBEn (idSrcBEn),
    .idSrcB   (idSrcB),
    .idDstEn  (idDstEn),
    .idDst    (idDst),
    .busyVec  (busyVec),
    .wbValid  (wbValid),
    .wbReg    (wbReg),
    .slotTaken(slotTaken),
    .divBusy  (divBusy),
    .stb      (stb),
    .latSel   (latSel),
    .stall    (stall)
  );

  iilk_dpath #(
    .NUM_REGS(NUM_REGS), .REG_W(REG_W), .DIV_LAT(DIV_LAT),
    .SLOT_N(SLOT_N), .LAT_W(LAT_W)
  ) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .latSel   (latSel),
    .idDst    (idDst),
    .busyVec  (busyVec),
    .slotTaken(slotTaken),
    .wbValid  (wbValid),
    .wbReg    (wbReg),
    .divBusy  (divBusy)
  );

  assign issue = stb.issue;

endmodule

// File: rtl/iilk_checker.sv
module iilk_checker #(
  parameter int NUM_REGS = 32,
  parameter int REG_W    = $clog2(NUM_REGS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                idValid,
  input logic [1:0]          idUnit,
  input logic                idSrcAEn,
  input logic [REG_W-1:0]    idSrcA,
  input logic                idSrcBEn,
  input logic [REG_W-1:0]    idSrcB,
  input logic                idDstEn,
  input logic [REG_W-1:0]    idDst,
  input logic                issue,
  input logic                stall,
  input logic [NUM_REGS-1:0] busyVec,
  input logic                wbValid,
  input logic [REG_W-1:0]    wbReg,
  input logic                divBusy
);

  assert_issue_stall_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue && stall));

  assert_issue_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue || stall) |-> idValid);

  assert_no_raw_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && idSrcAEn) |-> (!busyVec[idSrcA] || (wbValid && wbReg == idSrcA)));

  assert_no_raw_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && idSrcBEn) |-> (!busyVec[idSrcB] || (wbValid && wbReg == idSrcB)));

  assert_no_waw_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && idDstEn) |-> (!busyVec[idDst] || (wbValid && wbReg == idDst)));

  assert_dst_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && idDstEn) |=> busyVec[$past(idDst)]);

  assert_wb_was_flagged_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> busyVec[wbReg]);

  assert_div_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (idUnit == 2'd3 && divBusy) |-> !issue);

  assert_div_occupies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && idUnit == 2'd3) |=> divBusy);

endmodule

bind fp_issue_interlock iilk_checker #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .idValid(idValid), .idUnit(idUnit),
  .idSrcAEn(idSrcAEn), .idSrcA(idSrcA), .idSrcBEn(idSrcBEn), .idSrcB(idSrcB),
  .idDstEn(idDstEn), .idDst(idDst), .issue(issue), .stall(stall),
  .busyVec(busyVec), .wbValid(wbValid), .wbReg(wbReg), .divBusy(divBusy)
);

// File: tb/sim_fp_issue_interlock.sv
module sim_fp_issue_interlock;

  localparam int NR = 32;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          idValid, idSrcAEn, idSrcBEn, idDstEn;
  logic [1:0]    idUnit;
  logic [RW-1:0] idSrcA, idSrcB, idDst;
  logic          issue, stall, wbValid, divBusy;
  logic [NR-1:0] busyVec;
  logic [RW-1:0] wbReg;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;  // 250 MHz

  fp_issue_interlock u0 (
    .clk(clk), .rst_n(rst_n), .idValid(idValid), .idUnit(idUnit),
    .idSrcAEn(idSrcAEn), .idSrcA(idSrcA), .idSrcBEn(idSrcBEn), .idSrcB(idSrcB),
    .idDstEn(idDstEn), .idDst(idDst), .issue(issue), .stall(stall),
    .busyVec(busyVec), .wbValid(wbValid), .wbReg(wbReg), .divBusy(divBusy)
  );

  typedef struct packed {
    logic          v;
    logic [1:0]    u;
    logic          aEn;
    logic [RW-1:0] a;
    logic          bEn;
    logic [RW-1:0] b;
    logic          dEn;
    logic [RW-1:0] d;
    logic          expIssue;
  } vec_t;

  // One vector per consecutive cycle; units 0 int, 1 add, 2 mul, 3 div
  localparam vec_t VEC [14] = '{
    '{1'b1, 2'd2, 1'b1, 5'd1,  1'b1, 5'd2,  1'b1, 5'd4,  1'b1}, // c0 mul r4, wb c7
    '{1'b1, 2'd1, 1'b1, 5'd4,  1'b0, 5'd0,  1'b1, 5'd16, 1'b0}, // c1 RAW on r4 (R3)
    '{1'b1, 2'd1, 1'b1, 5'd5,  1'b1, 5'd6,  1'b1, 5'd4,  1'b0}, // c2 WAW on r4 (R4)
    '{1'b1, 2'd1, 1'b1, 5'd1,  1'b1, 5'd2,  1'b1, 5'd8,  1'b0}, // c3 wb c7 taken (R8)
    '{1'b1, 2'd1, 1'b1, 5'd1,  1'b1, 5'd2,  1'b1, 5'd8,  1'b1}, // c4 add r8, wb c8
    '{1'b1, 2'd0, 1'b1, 5'd3,  1'b0, 5'd0,  1'b1, 5'd9,  1'b1}, // c5 int r9, wb c6
    '{1'b1, 2'd3, 1'b1, 5'd1,  1'b1, 5'd2,  1'b1, 5'd10, 1'b1}, // c6 div r10, wb c30
    '{1'b1, 2'd1, 1'b1, 5'd4,  1'b0, 5'd0,  1'b1, 5'd12, 1'b1}, // c7 reads r4 in its wb cycle (R3)
    '{1'b1, 2'd3, 1'b1, 5'd1,  1'b0, 5'd0,  1'b1, 5'd11, 1'b0}, // c8 divider occupied (R7)
    '{1'b1, 2'd0, 1'b1, 5'd10, 1'b0, 5'd0,  1'b1, 5'd13, 1'b0}, // c9 RAW on r10 (R3)
    '{1'b1, 2'd2, 1'b1, 5'd8,  1'b0, 5'd0,  1'b1, 5'd14, 1'b1}, // c10 r8 freed after c8
    '{1'b1, 2'd2, 1'b1, 5'd1,  1'b0, 5'd0,  1'b1, 5'd15, 1'b1}, // c11 mul r15
    '{1'b0, 2'd0, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0}, // c12 no instruction (R2)
    '{1'b1, 2'd0, 1'b1, 5'd4,  1'b0, 5'd10, 1'b0, 5'd10, 1'b1}  // c13 disabled src/dst ignored (R3,R4)
  };

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // Applies inputs for one cycle; outputs are sampled 1 ns before the next edge
  task automatic drive(input logic v, input logic [1:0] u,
                       input logic aEn, input logic [RW-1:0] a,
                       input logic bEn, input logic [RW-1:0] b,
                       input logic dEn, input logic [RW-1:0] d);
    @(negedge clk);
    idValid = v; idUnit = u; idSrcAEn = aEn; idSrcA = a;
    idSrcBEn = bEn; idSrcB = b; idDstEn = dEn; idDst = d;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 1'b0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    idle();
    repeat (3) @(posedge clk);
    #1;
    chk(busyVec == '0 && !wbValid && !divBusy, "R1 state during reset",
        int'({busyVec != '0, wbValid, divBusy}), 0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic latTest(input logic [1:0] u, input logic [RW-1:0] d, input int expLat);
    int wbAt = -1;
    bit busyOk = 1;
    drive(1'b1, u, 1'b0, '0, 1'b0, '0, 1'b1, d);
    chk(issue === 1'b1, "R5 latency probe issues", int'(issue), 1);
    for (int k = 1; k <= 40; k++) begin
      idle();
      if (wbValid && wbReg == d && wbAt < 0) wbAt = k;
      if (busyVec[d] !== (k <= expLat)) busyOk = 0;
    end
    chk(wbAt == expLat, "R5 write-back latency", wbAt, expLat);
    chk(busyOk, "R6 pending-write window", int'(busyOk), 1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    idValid = 0; idUnit = 0; idSrcAEn = 0; idSrcA = 0;
    idSrcBEn = 0; idSrcB = 0; idDstEn = 0; idDst = 0;
    doReset();

    // Table walk (R2, R3, R4, R7, R8)
    for (int i = 0; i < 14; i++) begin
      drive(VEC[i].v, VEC[i].u, VEC[i].aEn, VEC[i].a, VEC[i].bEn, VEC[i].b,
            VEC[i].dEn, VEC[i].d);
      chk(issue === VEC[i].expIssue, $sformatf("R2 vector %0d issue", i),
          int'(issue), int'(VEC[i].expIssue));
      chk(stall === (VEC[i].v && !VEC[i].expIssue), $sformatf("R2 vector %0d stall", i),
          int'(stall), int'(VEC[i].v && !VEC[i].expIssue));
    end

    // R1: fresh reset, then an independent instruction issues at once
    doReset();
    idle();
    chk(busyVec == '0 && !wbValid && !divBusy, "R1 state after reset",
        int'({busyVec != '0, wbValid, divBusy}), 0);
    drive(1'b1, 2'd1, 1'b1, 5'd3, 1'b1, 5'd4, 1'b1, 5'd5);
    chk(issue === 1'b1, "R1 first instruction issues", int'(issue), 1);
    repeat (10) idle();

    // R5/R6 per unit latency
    latTest(2'd0, 5'd17, 1);
    latTest(2'd1, 5'd18, 4);
    latTest(2'd2, 5'd19, 7);
    latTest(2'd3, 5'd20, 24);

    // R7 divider occupancy
    drive(1'b1, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1, 5'd20);
    chk(issue === 1'b1, "R7 first divide issues", int'(issue), 1);
    for (int k = 1; k <= 25; k++) begin
      if (k == 10) begin
        drive(1'b1, 2'd0, 1'b1, 5'd22, 1'b0, '0, 1'b1, 5'd21);
        chk(issue === 1'b1, "R7 integer op ignores busy divider", int'(issue), 1);
        chk(divBusy === 1'b1, "R7 divider busy mid-run", int'(divBusy), 1);
      end else if (k == 24) begin
        drive(1'b1, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1, 5'd23);
        chk(stall === 1'b1, "R7 independent divide waits", int'(stall), 1);
        chk(divBusy === 1'b1, "R7 divider busy in write-back cycle", int'(divBusy), 1);
      end else if (k == 25) begin
        drive(1'b1, 2'd3, 1'b0, '0, 1'b0, '0, 1'b1, 5'd23);
        chk(divBusy === 1'b0, "R7 divider free after write-back", int'(divBusy), 0);
        chk(issue === 1'b1, "R7 divide issues once free", int'(issue), 1);
      end else begin
        idle();
      end
    end
    repeat (30) idle();

    // R9 out-of-order completion
    begin
      int firstReg = -1;
      int secondReg = -1;
      drive(1'b1, 2'd2, 1'b0, '0, 1'b0, '0, 1'b1, 5'd5);
      drive(1'b1, 2'd0, 1'b0, '0, 1'b0, '0, 1'b1, 5'd6);
      for (int k = 0; k < 12; k++) begin
        idle();
        if (wbValid) begin
          if (firstReg < 0) firstReg = int'(wbReg);
          else if (secondReg < 0) secondReg = int'(wbReg);
        end
      end
      chk(firstReg == 6, "R9 younger integer op writes back first", firstReg, 6);
      chk(secondReg == 5, "R9 older multiply writes back second", secondReg, 5);
    end

    // R4/R6: new writer claims a register in its write-back cycle
    drive(1'b1, 2'd1, 1'b0, '0, 1'b0, '0, 1'b1, 5'd7);
    repeat (3) idle();
    drive(1'b1, 2'd0, 1'b0, '0, 1'b0, '0, 1'b1, 5'd7);
    chk(issue === 1'b1 && wbValid && wbReg == 5'd7, "R4 claim during write-back issues",
        int'(issue), 1);
    idle();
    chk(busyVec[7] === 1'b1 && wbValid && wbReg == 5'd7, "R6 flag held by new writer",
        int'(busyVec[7]), 1);
    idle();
    chk(busyVec[7] === 1'b0, "R6 flag clears after second write-back", int'(busyVec[7]), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule